// File: doc/BRIEF.md
# Command-Driven Reset and Register Controller

This block sits behind the byte interface of a serial-bus slave in a data-bus interface peripheral. It holds four configuration registers: transmit control, two receiver controls and a reference clock divider. It also owns the reset policy of the peripheral. Every transaction starts with a one-byte op-code, marked by `byte_first`. Write op-codes take the byte that follows as the new register value. Read op-codes return the register on `rd_data`. One op-code requests a software reset.

There are two reset sources, and they clear different amounts of state. The asynchronous master reset pin is synchronised and stretched. While it is active, the block zeroes every configuration register and raises the clear strobes to the three FIFOs, the six mailboxes, the filter memories and the match registers. A software reset pulses only the FIFO and mailbox strobes, so configuration and filtering survive while buffered data is flushed. The storage blocks themselves are outside and see only the strobes. Downstream status logic therefore sees the emptied state on the cycle right after the command.

Top module: `cmd_reset_ctrl`

## Requirements
- R1: A high level on `mreset_in` of N cycles, driven between clock edges, raises all of `fifo_clr`, `mbox_clr`, `filt_clr` and `match_clr` after the third rising edge. They stay high for exactly N + MR_HOLD - 1 cycles (MR_HOLD = 2 by default), and `filt_clr`/`match_clr` never rise without the FIFO and mailbox strobes.
- R2: After a master reset all four configuration outputs read 0x00. Bytes received while the master reset is active are ignored and produce no `rd_vld`.
- R3: Op-code 0x04 pulses every bit of `fifo_clr` and `mbox_clr` high for exactly one cycle, the cycle after the edge that samples the op-code byte. `filt_clr` and `match_clr` stay low.
- R4: A software reset leaves all four configuration registers unchanged.
- R5: A write op-code followed by a data byte (with `byte_first` low) updates the selected register at the edge sampling the data byte. The write op-codes are 0x08 transmit control, 0x10 receiver 0 control, 0x24 receiver 1 control and 0x38 clock divider.
- R6: Every op-code byte gives a one-cycle `rd_vld` on the following cycle. For the read op-codes, `rd_data` then holds the current register value: 0x84 transmit control, 0x94 receiver 0, 0xB4 receiver 1 and 0xD4 clock divider. For all other op-codes `rd_data` is 0x00.
- R7: The clock divider keeps only bits 4..1 of a written byte; bits 7, 6, 5 and 0 always read 0, which limits the value to 0x1E.
- R8: An unknown op-code changes no register and raises no strobe. A data byte with no pending write is ignored and raises no `rd_vld`.
- R9: After `rst_n` is released, every output is 0.
- R10: An op-code byte that arrives while a write waits for its data cancels that write. If it is itself a write op-code, the next data byte goes to its own register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| mreset_in | input | 1 | Asynchronous master reset pin, active high |
| byte_vld | input | 1 | A received byte is present this cycle |
| byte_first | input | 1 | The present byte is an op-code |
| byte_in | input | 8 | Received byte |
| rd_vld | output | 1 | Read-back byte valid, one cycle per op-code |
| rd_data | output | 8 | Read-back byte |
| tx_ctrl | output | 8 | Transmit control register |
| rx0_ctrl | output | 8 | Receiver 0 control register |
| rx1_ctrl | output | 8 | Receiver 1 control register |
| clk_div | output | 8 | Clock divider register |
| fifo_clr | output | 3 | Clear strobes, one per FIFO |
| mbox_clr | output | 6 | Clear strobes, one per mailbox |
| filt_clr | output | 1 | Filter memory clear strobe |
| match_clr | output | 1 | Match register clear strobe |

## Verification
The bench measures the length of the master-reset strobe for pulses of one and several cycles. A design that dropped the stretch counter, or counted it off by one, would give too short a clear window, and one that skipped the synchroniser would raise the strobes early. Software resets are checked one cycle later to confirm that the strobes fall and that the filter and match strobes never moved, which catches a design that merged the two reset paths or cleared configuration. Writes are cancelled by a second op-code, stray data bytes are sent, and random bytes go to the clock divider. A design that wrote the stale register, accepted orphan data or stored the fixed-zero bits would fail the read-back.

// File: rtl/crc_pkg.sv
package crc_pkg;
    localparam int DW        = 8;
    localparam int REG_COUNT = 4;
    localparam int IDX_W     = $clog2(REG_COUNT);

    // register index order: transmit, receiver 0, receiver 1, divider
    localparam logic [IDX_W-1:0] DIV_IDX = IDX_W'(3);
    localparam logic [DW-1:0]    DIV_KEEP = 8'h1E;

    localparam logic [DW-1:0] OP_SOFT_RST = 8'h04;
    localparam logic [REG_COUNT-1:0][DW-1:0] OP_WRITE = {8'h38, 8'h24, 8'h10, 8'h08};
    localparam logic [REG_COUNT-1:0][DW-1:0] OP_READ  = {8'hD4, 8'hB4, 8'h94, 8'h84};

    typedef enum logic [1:0] {
        CK_NONE,
        CK_SOFT,
        CK_WRITE,
        CK_READ
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } cmd_dec_t;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT_DATA
    } ctl_state_e;
endpackage

// File: rtl/crc_mr_stretch.sv
module crc_mr_stretch #(
    parameter int SYNC_STAGES = 2,
    parameter int MR_HOLD     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mr_async,
    output logic mr_active
);
    localparam int CW = $clog2(MR_HOLD + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
    } mr_state_t;

    mr_state_t st_d, st_q;
    logic      sync_out;

    assign sync_out  = st_q.sync[SYNC_STAGES-1];
    assign mr_active = sync_out || (st_q.cnt != '0);

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], mr_async};
        if (sync_out) begin
            st_d.cnt = CW'(MR_HOLD - 1);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (MR_HOLD >= 2) begin : g_min_hold
            AST_MR_MIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(mr_active) |=> mr_active); // R1
        end
    endgenerate
endmodule

// File: rtl/crc_opdec.sv
module crc_opdec
    import crc_pkg::*;
(
    input  logic [DW-1:0] op,
    output cmd_dec_t      dec
);
    always_comb begin
        dec.kind = CK_NONE;
        dec.idx  = '0;
        if (op == OP_SOFT_RST) begin
            dec.kind = CK_SOFT;
        end
        for (int i = 0; i < REG_COUNT; i++) begin
            if (op == OP_WRITE[i]) begin
                dec.kind = CK_WRITE;
                dec.idx  = IDX_W'(i);
            end
            if (op == OP_READ[i]) begin
                dec.kind = CK_READ;
                dec.idx  = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/crc_cfg_file.sv
module crc_cfg_file
    import crc_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [DW-1:0]               wr_data,
    output logic [REG_COUNT-1:0][DW-1:0] regs
);
    logic [REG_COUNT-1:0][DW-1:0] regs_d, regs_q;

    generate
        for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
            always_comb begin
                if (clr) begin
                    regs_d[g] = '0;
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    regs_d[g] = wr_data;
                end else begin
                    regs_d[g] = regs_q[g];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs = regs_q;

    AST_DIV_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q[DIV_IDX] & ~DIV_KEEP) == '0); // R7
endmodule

// File: rtl/cmd_reset_ctrl.sv
module cmd_reset_ctrl
    import crc_pkg::*;
#(
    parameter int N_FIFO      = 3,
    parameter int N_MBOX      = 6,
    parameter int SYNC_STAGES = 2,
    parameter int MR_HOLD     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mreset_in,
    input  logic              byte_vld,
    input  logic              byte_first,
    input  logic [DW-1:0]     byte_in,
    output logic              rd_vld,
    output logic [DW-1:0]     rd_data,
    output logic [DW-1:0]     tx_ctrl,
    output logic [DW-1:0]     rx0_ctrl,
    output logic [DW-1:0]     rx1_ctrl,
    output logic [DW-1:0]     clk_div,
    output logic [N_FIFO-1:0] fifo_clr,
    output logic [N_MBOX-1:0] mbox_clr,
    output logic              filt_clr,
    output logic              match_clr
);
    typedef struct packed {
        ctl_state_e        st;
        logic [IDX_W-1:0]  widx;
        logic              rd_vld;
        logic [DW-1:0]     rd_data;
        logic [N_FIFO-1:0] fifo_clr;
        logic [N_MBOX-1:0] mbox_clr;
        logic              filt_clr;
        logic              match_clr;
    } ctl_t;

    ctl_t                         c_d, c_q;
    logic                         mr_active;
    cmd_dec_t                     dec;
    logic                         wr_en;
    logic [DW-1:0]                wr_data;
    logic [REG_COUNT-1:0][DW-1:0] cfg;

    crc_mr_stretch #(
        .SYNC_STAGES (SYNC_STAGES),
        .MR_HOLD     (MR_HOLD)
    ) u_mr (
        .clk       (clk),
        .rst_n     (rst_n),
        .mr_async  (mreset_in),
        .mr_active (mr_active)
    );

    crc_opdec u_dec (
        .op  (byte_in),
        .dec (dec)
    );

    crc_cfg_file u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (mr_active),
        .wr_en   (wr_en),
        .wr_idx  (c_q.widx),
        .wr_data (wr_data),
        .regs    (cfg)
    );

    assign wr_data = byte_in & ((c_q.widx == DIV_IDX) ? DIV_KEEP : {DW{1'b1}});

    always_comb begin
        c_d           = c_q;
        c_d.rd_vld    = 1'b0;
        c_d.fifo_clr  = '0;
        c_d.mbox_clr  = '0;
        c_d.filt_clr  = 1'b0;
        c_d.match_clr = 1'b0;
        wr_en         = 1'b0;
        if (mr_active) begin
            c_d.st        = ST_IDLE;
            c_d.rd_data   = '0;
            c_d.fifo_clr  = '1;
            c_d.mbox_clr  = '1;
            c_d.filt_clr  = 1'b1;
            c_d.match_clr = 1'b1;
        end else if (byte_vld) begin
            if (byte_first) begin
                c_d.st      = ST_IDLE;
                c_d.rd_vld  = 1'b1;
                c_d.rd_data = '0;
                case (dec.kind)
                    CK_SOFT: begin
                        c_d.fifo_clr = '1;
                        c_d.mbox_clr = '1;
                    end
                    CK_WRITE: begin
                        c_d.st   = ST_WAIT_DATA;
                        c_d.widx = dec.idx;
                    end
                    CK_READ: begin
                        c_d.rd_data = cfg[dec.idx];
                    end
                    default: ;
                endcase
            end else if (c_q.st == ST_WAIT_DATA) begin
                wr_en  = 1'b1;
                c_d.st = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rd_vld    = c_q.rd_vld;
    assign rd_data   = c_q.rd_data;
    assign tx_ctrl   = cfg[0];
    assign rx0_ctrl  = cfg[1];
    assign rx1_ctrl  = cfg[2];
    assign clk_div   = cfg[3];
    assign fifo_clr  = c_q.fifo_clr;
    assign mbox_clr  = c_q.mbox_clr;
    assign filt_clr  = c_q.filt_clr;
    assign match_clr = c_q.match_clr;

    AST_FILT_WITH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_clr || match_clr) |-> (filt_clr && match_clr && (&fifo_clr) && (&mbox_clr))); // R1
    AST_CLR_GROUPED: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_clr != '0) |-> ((&fifo_clr) && (&mbox_clr))); // R3
    AST_RD_AFTER_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> $past(byte_vld && byte_first && !mr_active)); // R6
    AST_MR_CLEARS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mr_active) |-> (cfg == '0 && !rd_vld)); // R2
endmodule

// File: tb/tb_cmd_reset_ctrl.sv
`timescale 1ns/1ps
module tb_cmd_reset_ctrl;
    localparam int MR_HOLD = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mreset_in = 1'b0;
    logic       byte_vld = 1'b0;
    logic       byte_first = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       rd_vld;
    logic [7:0] rd_data, tx_ctrl, rx0_ctrl, rx1_ctrl, clk_div;
    logic [2:0] fifo_clr;
    logic [5:0] mbox_clr;
    logic       filt_clr, match_clr;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [7:0] exp_reg [4];

    always #2 clk = ~clk;

    cmd_reset_ctrl #(.MR_HOLD(MR_HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .mreset_in(mreset_in),
        .byte_vld(byte_vld), .byte_first(byte_first), .byte_in(byte_in),
        .rd_vld(rd_vld), .rd_data(rd_data),
        .tx_ctrl(tx_ctrl), .rx0_ctrl(rx0_ctrl), .rx1_ctrl(rx1_ctrl), .clk_div(clk_div),
        .fifo_clr(fifo_clr), .mbox_clr(mbox_clr), .filt_clr(filt_clr), .match_clr(match_clr)
    );

    function automatic logic [7:0] wr_op(int i);
        case (i) 0: return 8'h08; 1: return 8'h10; 2: return 8'h24; default: return 8'h38; endcase
    endfunction
    function automatic logic [7:0] rd_op(int i);
        case (i) 0: return 8'h84; 1: return 8'h94; 2: return 8'hB4; default: return 8'hD4; endcase
    endfunction
    function automatic logic [7:0] stored(int i, logic [7:0] d);
        return (i == 3) ? (d & 8'h1E) : d;
    endfunction
    function automatic bit known(logic [7:0] b);
        if (b == 8'h04) return 1;
        for (int i = 0; i < 4; i++) if (b == wr_op(i) || b == rd_op(i)) return 1;
        return 0;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(logic first, logic [7:0] b);
        byte_vld = 1'b1; byte_first = first; byte_in = b;
        @(negedge clk);
        byte_vld = 1'b0; byte_first = 1'b0;
    endtask

    task automatic chk_regs(string req);
        chk(req, {tx_ctrl, rx0_ctrl, rx1_ctrl, clk_div},
            {exp_reg[0], exp_reg[1], exp_reg[2], exp_reg[3]});
    endtask

    task automatic do_write(int i, logic [7:0] d);
        send(1'b1, wr_op(i));
        chk("R6 write opcode rd_data", {rd_vld, rd_data}, {1'b1, 8'h00});
        send(1'b0, d);
        exp_reg[i] = stored(i, d);
        chk_regs((i == 3) ? "R7 divider mask" : "R5 write");
    endtask

    task automatic do_read(int i);
        send(1'b1, rd_op(i));
        chk("R6 read back", {rd_vld, rd_data}, {1'b1, exp_reg[i]});
        @(negedge clk);
        chk("R6 rd_vld one cycle", rd_vld, 0);
    endtask

    task automatic do_soft();
        send(1'b1, 8'h04);
        chk("R3 soft strobes", {fifo_clr, mbox_clr, filt_clr, match_clr}, {3'b111, 6'h3F, 2'b00});
        @(negedge clk);
        chk("R3 soft strobes drop", {fifo_clr, mbox_clr, filt_clr, match_clr}, 0);
        chk_regs("R4 config kept");
    endtask

    task automatic do_master(int n, bit with_bytes);
        int first_hi = -1;
        int hi_cnt = 0;
        mreset_in = 1'b1;
        for (int k = 1; k <= n + MR_HOLD + 8; k++) begin
            if (with_bytes && k == 4) begin
                byte_vld = 1'b1; byte_first = 1'b1; byte_in = 8'h08;
            end else if (with_bytes && k == 5) begin
                byte_vld = 1'b1; byte_first = 1'b0; byte_in = 8'h5A;
            end else begin
                byte_vld = 1'b0; byte_first = 1'b0;
            end
            @(negedge clk);
            if (k == n) mreset_in = 1'b0;
            if (with_bytes && k >= 4 && k <= 6) chk("R2 no read during master reset", rd_vld, 0);
            if ((&fifo_clr) && (&mbox_clr) && filt_clr && match_clr) begin
                if (first_hi < 0) first_hi = k;
                hi_cnt++;
            end
        end
        byte_vld = 1'b0;
        chk("R1 strobe start", first_hi, 3);
        chk("R1 strobe length", hi_cnt, n + MR_HOLD - 1);
        for (int i = 0; i < 4; i++) exp_reg[i] = 8'h00;
        chk_regs("R2 config cleared");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        void'($urandom(32'd1234));
        for (int i = 0; i < 4; i++) exp_reg[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset state", {rd_vld, rd_data, tx_ctrl, rx0_ctrl, rx1_ctrl, clk_div}, 0);
        chk("R9 reset strobes", {fifo_clr, mbox_clr, filt_clr, match_clr}, 0);

        // directed corners
        do_write(3, 8'hFF);
        do_read(3);
        do_write(3, 8'h01);
        do_write(0, 8'hA5);
        do_write(1, 8'h3C);
        do_write(2, 8'hC3);
        do_soft();
        do_read(0);

        // R10: write cancelled by a read op-code, then orphan data ignored
        send(1'b1, wr_op(1));
        send(1'b1, rd_op(2));
        chk("R10 replacing read", {rd_vld, rd_data}, {1'b1, exp_reg[2]});
        send(1'b0, 8'h77);
        chk("R8 orphan data no rd_vld", rd_vld, 0);
        chk_regs("R10 cancelled write");
        // R10: second write op-code takes the data
        send(1'b1, wr_op(0));
        send(1'b1, wr_op(2));
        send(1'b0, 8'h99);
        exp_reg[2] = 8'h99;
        chk_regs("R10 retargeted write");
        // soft reset cancels a pending write
        send(1'b1, wr_op(1));
        do_soft();
        send(1'b0, 8'h42);
        chk_regs("R10 soft cancels write");

        do_master(1, 1'b0);
        do_write(0, 8'h11);
        do_master(4, 1'b1);

        // constrained random mix
        for (int it = 0; it < 400; it++) begin
            int sel = $urandom_range(9, 0);
            int r = $urandom_range(3, 0);
            b = 8'($urandom);
            if (sel < 3) do_write(r, b);
            else if (sel < 6) do_read(r);
            else if (sel == 6) do_soft();
            else if (sel == 7) begin
                while (known(b)) b = 8'($urandom);
                send(1'b1, b);
                chk("R8 unknown op reads zero", {rd_vld, rd_data}, {1'b1, 8'h00});
                chk("R8 unknown op no strobe", {fifo_clr, mbox_clr, filt_clr, match_clr}, 0);
                chk_regs("R8 unknown op no change");
            end else if (sel == 8) begin
                send(1'b0, b);
                chk("R8 stray data ignored", rd_vld, 0);
                chk_regs("R8 stray data no change");
            end else begin
                do_write(3, b);
            end
        end
        do_master(2, 1'b0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule